// File: doc/BRIEF.md
# E3 Remote Defect Indication Monitor

The monitor follows the remote-alarm bit that the upstream frame alignment logic pulls out of every received E3 frame, and it keeps a filtered far-end receive failure state. The bit is only looked at when a frame strobe marks it valid. While the state is clear, a run of frames with the bit set declares the defect. While the state is set, a run of frames with the bit clear removes it. The run length is either short (3 frames) or long (5 frames). A configuration bit picks it at run time.

Every change of state, in either direction, latches a change flag. That flag pulls an active-low interrupt pin when interrupts are enabled. The host reaches the block through a small byte-wide register port with a single-cycle write strobe and a combinational read. The port carries the configuration, the live defect status and the write-one-to-clear change flag.

Top module: `e3_rdi_monitor`

## Requirements
- R1: After reset the defect status is 0, the change flag is 0, the configuration reads 0x00 and `irq_no` is high.
- R2: With the run-length select at 0, 3 consecutive strobed frames whose alarm bit differs from the current state toggle the state. A defect is declared by alarm bit 1 and cleared by alarm bit 0. Fewer than 3 such frames leave the state unchanged.
- R3: With the run-length select at 1, the run is 5 consecutive strobed frames. 4 such frames leave the state unchanged.
- R4: A strobed frame whose alarm bit equals the current state restarts the run count from zero.
- R5: Cycles with `frame_stb_i` low have no effect on the run count or the state, whatever the value of `a_bit_i`.
- R6: Register map:
  - Address 0 is configuration. Bit 4 is the run-length select and bit 1 is the interrupt enable. Its other bits read 0.
  - Address 1 is status. Bit 0 is the defect state. Writes to it are ignored.
  - Address 3 reads 0x00.
- R7: Every toggle of the defect state sets the change flag, read at address 2 bit 3, in the same cycle the state changes.
- R8: Writing a byte with bit 3 set to address 2 clears the change flag. Writing a byte with bit 3 at 0 leaves it unchanged. A toggle in the same cycle as the clear wins.
- R9: `irq_no` is low exactly when the change flag is 1 and the interrupt enable is 1.
- R10: A change of the run-length select during a run takes effect on the next strobed frame without resetting the count. For example, 4 frames counted in long mode followed by a switch to short mode toggle the state on the next differing frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_stb_i | input | 1 | One-cycle pulse marking a valid alarm bit |
| a_bit_i | input | 1 | Remote-alarm bit of the current frame |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| rdi_defect_o | output | 1 | Filtered defect state |
| irq_no | output | 1 | Active-low interrupt |

## Verification
Several properties are checked on every cycle:
- the run count stays below the long run length;
- the defect state moves only in a cycle after a frame strobe;
- a frame that agrees with the state leaves the count at zero;
- the change flag rises only on a toggle and always follows one;
- a clear without a simultaneous toggle drops the flag.

Only the directed scenarios can show the rest:
- the exact run lengths in both modes;
- the restart of a broken run;
- the effect of a mid-run mode switch;
- the masking of the pin;
- the read-back of unused and read-only bits.

// File: rtl/rdi_pkg.sv
package rdi_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] ADDR_CFG  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_IRQ  = 2'd2;

  localparam int unsigned CFG_LONG_BIT = 4;
  localparam int unsigned CFG_IEN_BIT  = 1;
  localparam int unsigned STAT_DEF_BIT = 0;
  localparam int unsigned IRQ_CHG_BIT  = 3;

  localparam logic [REG_DW-1:0] CFG_WMASK =
    REG_DW'((1 << CFG_LONG_BIT) | (1 << CFG_IEN_BIT));

  typedef struct packed {
    logic long_run;
    logic irq_en;
  } cfg_t;
endpackage

// File: rtl/rdi_run_counter.sv
module rdi_run_counter #(
  parameter int unsigned SHORT_RUN = 3,
  parameter int unsigned LONG_RUN  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_stb_i,
  input  logic a_bit_i,
  input  logic long_sel_i,
  output logic defect_o,
  output logic change_o
);
  localparam int unsigned CNT_W = $clog2(LONG_RUN + 1);
  localparam logic [CNT_W-1:0] THR_S = CNT_W'(SHORT_RUN);
  localparam logic [CNT_W-1:0] THR_L = CNT_W'(LONG_RUN);

  logic [CNT_W-1:0] cnt_q, cnt_inc, thr;
  logic             defect_q, differs;

  always_comb begin
    thr      = long_sel_i ? THR_L : THR_S;
    cnt_inc  = cnt_q + 1'b1;
    differs  = a_bit_i != defect_q;
    change_o = frame_stb_i && differs && (cnt_inc >= thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      defect_q <= 1'b0;
    end else if (frame_stb_i) begin
      if (!differs) begin
        cnt_q <= '0;
      end else if (change_o) begin
        cnt_q    <= '0;
        defect_q <= ~defect_q;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign defect_o = defect_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < THR_L);

  // R5
  defect_on_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(defect_q) |-> $past(frame_stb_i));

  // R4
  run_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_i && (a_bit_i == defect_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/rdi_irq_latch.sv
module rdi_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_no
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_no = ~(flag_q & en_i);

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

  // R7
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i));

  // R8
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/rdi_cfg_regs.sv
module rdi_cfg_regs
  import rdi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              defect_i,
  input  logic              flag_i,
  output cfg_t              cfg_o,
  output logic              flag_clr_o,
  output logic [REG_DW-1:0] rdata_o
);
  logic [REG_DW-1:0] cfg_q, wmasked;

  assign wmasked = wdata_i & CFG_WMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cfg_q <= '0;
    else if (we_i && addr_i == ADDR_CFG)  cfg_q <= wmasked;
  end

  assign cfg_o.long_run = cfg_q[CFG_LONG_BIT];
  assign cfg_o.irq_en   = cfg_q[CFG_IEN_BIT];
  assign flag_clr_o     = we_i && (addr_i == ADDR_IRQ) && wdata_i[IRQ_CHG_BIT];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CFG:  rdata_o = cfg_q;
      ADDR_STAT: rdata_o[STAT_DEF_BIT] = defect_i;
      ADDR_IRQ:  rdata_o[IRQ_CHG_BIT] = flag_i;
      default:   rdata_o = '0;
    endcase
  end

  // R6
  cfg_unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q & ~CFG_WMASK) == '0);
endmodule

// File: rtl/e3_rdi_monitor.sv
module e3_rdi_monitor
  import rdi_pkg::*;
#(
  parameter int unsigned SHORT_RUN = 3,
  parameter int unsigned LONG_RUN  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_stb_i,
  input  logic              a_bit_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              rdi_defect_o,
  output logic              irq_no
);
  cfg_t cfg;
  logic defect, change, flag, flag_clr;

  rdi_run_counter #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_stb_i (frame_stb_i),
    .a_bit_i     (a_bit_i),
    .long_sel_i  (cfg.long_run),
    .defect_o    (defect),
    .change_o    (change)
  );

  rdi_irq_latch u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (change),
    .clr_i  (flag_clr),
    .en_i   (cfg.irq_en),
    .flag_o (flag),
    .irq_no (irq_no)
  );

  rdi_cfg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .defect_i   (defect),
    .flag_i     (flag),
    .cfg_o      (cfg),
    .flag_clr_o (flag_clr),
    .rdata_o    (reg_rdata_o)
  );

  assign rdi_defect_o = defect;

  // R7
  toggle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdi_defect_o) |-> flag);
endmodule

// File: tb/tb_e3_rdi_monitor.sv
module tb_e3_rdi_monitor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic       abit = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       defect, irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e3_rdi_monitor dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_stb_i  (stb),
    .a_bit_i      (abit),
    .reg_we_i     (we),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .rdi_defect_o (defect),
    .irq_no       (irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic a);
    @(negedge clk); stb = 1'b1; abit = a;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic frames(input logic a, input int n);
    for (int i = 0; i < n; i++) frame(a);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  task automatic t_reset;
    expect_reg("R1 cfg", 2'd0, 8'h00);
    expect_reg("R1 stat", 2'd1, 8'h00);
    expect_reg("R1 flag", 2'd2, 8'h00);
    check("R1 irq_no", irq_n, 1);
  endtask

  task automatic t_short;
    wr(2'd0, 8'h02);
    frames(1'b1, 2);
    expect_reg("R2 not yet declared", 2'd1, 8'h00);
    frame(1'b1);
    expect_reg("R2 declared", 2'd1, 8'h01);
    expect_reg("R7 flag on declare", 2'd2, 8'h08);
    check("R9 irq low", irq_n, 0);
    wr(2'd2, 8'h08);
    expect_reg("R8 w1c", 2'd2, 8'h00);
    check("R9 irq high after clear", irq_n, 1);
    frames(1'b0, 2);
    expect_reg("R2 not yet cleared", 2'd1, 8'h01);
    frame(1'b0);
    expect_reg("R2 cleared", 2'd1, 8'h00);
    expect_reg("R7 flag on clear", 2'd2, 8'h08);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_run_break;
    frames(1'b1, 2); frame(1'b0); frames(1'b1, 2);
    expect_reg("R4 broken run", 2'd1, 8'h00);
    frame(1'b1);
    expect_reg("R4 restarted run", 2'd1, 8'h01);
    wr(2'd2, 8'h08);
    frames(1'b0, 2); frame(1'b1); frames(1'b0, 2);
    expect_reg("R4 broken clear run", 2'd1, 8'h01);
    frame(1'b0);
    expect_reg("R4 restarted clear run", 2'd1, 8'h00);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_gaps;
    @(negedge clk); abit = 1'b1;
    repeat (10) @(negedge clk);
    expect_reg("R5 idle ignored", 2'd1, 8'h00);
    expect_reg("R5 no flag", 2'd2, 8'h00);
    for (int i = 0; i < 3; i++) begin
      frame(1'b1);
      repeat (3) @(negedge clk);
    end
    expect_reg("R5 spaced frames", 2'd1, 8'h01);
    wr(2'd2, 8'h08);
    frames(1'b0, 3);
    expect_reg("R5 back clear", 2'd1, 8'h00);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_long;
    wr(2'd0, 8'h12);
    expect_reg("R6 cfg readback", 2'd0, 8'h12);
    frames(1'b1, 4);
    expect_reg("R3 four not enough", 2'd1, 8'h00);
    frame(1'b1);
    expect_reg("R3 declared at five", 2'd1, 8'h01);
    wr(2'd2, 8'h08);
    frames(1'b0, 4);
    expect_reg("R3 four not clearing", 2'd1, 8'h01);
    frame(1'b0);
    expect_reg("R3 cleared at five", 2'd1, 8'h00);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_switch;
    wr(2'd0, 8'h12);
    frames(1'b1, 4);
    wr(2'd0, 8'h02);
    expect_reg("R10 count kept", 2'd1, 8'h00);
    frame(1'b1);
    expect_reg("R10 long to short", 2'd1, 8'h01);
    wr(2'd2, 8'h08);
    frames(1'b0, 2);
    wr(2'd0, 8'h12);
    frames(1'b0, 2);
    expect_reg("R10 short to long holds", 2'd1, 8'h01);
    frame(1'b0);
    expect_reg("R10 short to long clears", 2'd1, 8'h00);
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h02);
  endtask

  task automatic t_regs;
    wr(2'd0, 8'hFF);
    expect_reg("R6 unused cfg bits", 2'd0, 8'h12);
    wr(2'd0, 8'h00);
    frames(1'b1, 3);
    expect_reg("R7 flag masked", 2'd2, 8'h08);
    check("R9 masked pin", irq_n, 1);
    wr(2'd2, 8'hF7);
    expect_reg("R8 zero write kept", 2'd2, 8'h08);
    wr(2'd1, 8'h00);
    expect_reg("R6 status read-only", 2'd1, 8'h01);
    wr(2'd0, 8'h02);
    check("R9 enable asserts pin", irq_n, 0);
    expect_reg("R6 addr3 zero", 2'd3, 8'h00);
    wr(2'd2, 8'h08);
    check("R9 pin released", irq_n, 1);
    frames(1'b0, 3);
    check("R2 defect port", defect, 0);
    wr(2'd2, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_run_break();
    t_gaps();
    t_long();
    t_switch();
    t_regs();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule